// File: doc/BRIEF.md
# UART FIFO Level and Timeout Interrupt Generator

This block sits next to the receive and transmit byte queues of one serial channel. It tracks how full each queue is and raises three interrupt requests. The receive-level request says enough characters are waiting. The receive-timeout request says a few characters have sat unread for too long. The transmit-level request says the transmit queue has room for more data. Software sets the block up with one control byte. That byte turns both queues on or off and selects a receive threshold and a transmit threshold, each from four values.

For compatibility with older parts, the transmit threshold stays at 8 characters after reset. A new transmit threshold written by software is kept in a shadow register. It only takes effect while the enhanced-mode input is high. The shadow value is kept when the enhanced-mode input goes low, so raising the input again brings the stored value back.

The block moves no data. Every queue event arrives as a one-cycle strobe and is accepted only when the occupancy model allows it: a load into a full queue is dropped, and a read from an empty queue does nothing. There is therefore no back-pressure handshake. All outputs are plain levels computed from registered state.

Top module: `uart_fifo_irq_gen`

## Requirements
- R1: After reset, both counts are 0, the queues are disabled, and all three interrupt outputs are low.
- R2: Bit 0 of the control byte enables the queues. A write with bit 0 clear empties both counts in the same cycle. While the queues are disabled, strobes do not change the counts and all interrupts stay low.
- R3: A 2-bit threshold code selects 00=8, 01=16, 10=56, 11=60 characters. The receive code is in control bits 7:6 and the transmit code is in bits 5:4.
- R4: `rx_level_irq` is high while the receive count is greater than or equal to the receive threshold, and low once the count drops below it.
- R5: `tx_level_irq` is high while the transmit count is at most 64 minus the effective transmit threshold.
- R6: While `enh_mode` is 0, the effective transmit threshold is 8 whatever code was written. While `enh_mode` is 1, the last written transmit code applies, and it is kept across changes of `enh_mode`.
- R7: Each count stays within 0..64. A load at 64 is dropped, a read at 0 is ignored, and a load and a read in the same cycle leave the count unchanged.
- R8: After a character is accepted into the receive queue, and with no read since, `rx_timeout_irq` rises once 40 baud ticks (4 characters of 10 bits) have been counted while the receive count is below the threshold.
- R9: Each accepted receive load restarts the timeout count. A holding-register read clears the timeout request, and the timeout stays low until the next load.
- R10: `rx_timeout_irq` stays low while the receive count is at or above the receive threshold, however many ticks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte: [0] enable, [5:4] transmit code, [7:6] receive code |
| enh_mode | input | 1 | Enhanced mode: applies the shadowed transmit code |
| rx_load | input | 1 | Character loaded into the receive queue |
| rhr_read | input | 1 | Receive holding register read |
| tx_write | input | 1 | Byte written into the transmit queue |
| tx_take | input | 1 | Byte taken by the transmit shifter |
| baud_tick | input | 1 | One pulse per bit time |
| rx_count | output | 7 | Receive queue occupancy |
| tx_count | output | 7 | Transmit queue occupancy |
| rx_level_irq | output | 1 | Receive threshold reached |
| rx_timeout_irq | output | 1 | Receive character timeout |
| tx_level_irq | output | 1 | Transmit room available |

## Verification
The hardest case to reach is a timeout that must not fire. This happens when a later load restarts the timer partway through, or when the queue is already at its threshold with a character still unread. The stimulus loads a character, sends 30 ticks, loads again, and checks that the timeout is still low after 30 more ticks and rises only after 10 further ticks. It then fills the queue to the threshold and sends 45 ticks to confirm the request stays low. For the transmit shadow, the bench writes a code while enhanced mode is off, toggles the mode at a fixed occupancy, and watches the transmit interrupt switch between the two thresholds.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_8  = 2'b00,
    TRIG_16 = 2'b01,
    TRIG_56 = 2'b10,
    TRIG_60 = 2'b11
  } trig_code_e;

  // Control byte fields
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_TX_LSB = 4;
  localparam int CTL_RX_LSB = 6;

  // Character counts for each threshold code
  localparam int unsigned LVL_A = 8;
  localparam int unsigned LVL_B = 16;
  localparam int unsigned LVL_C = 56;
  localparam int unsigned LVL_D = 60;

  function automatic int unsigned trig_chars(input trig_code_e code);
    case (code)
      TRIG_8:  return LVL_A;
      TRIG_16: return LVL_B;
      TRIG_56: return LVL_C;
      default: return LVL_D;
    endcase
  endfunction

endpackage

// File: rtl/fifo_occ.sv
module fifo_occ #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          enable,
  input  logic          push,
  input  logic          pop,
  output logic          push_ok,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic pop_ok;

  assign push_ok = enable && push && (cnt != FULL);
  assign pop_ok  = enable && pop  && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (flush)
      cnt <= '0;
    else if (push_ok && !pop_ok)
      cnt <= cnt + CW'(1);
    else if (pop_ok && !push_ok)
      cnt <= cnt - CW'(1);
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) ||
                cnt + CW'(1) == $past(cnt)));

endmodule

// File: rtl/trig_ctl.sv
module trig_ctl
  import uart_fifo_irq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_data,
  input  logic          enh_mode,
  output logic          fifo_en,
  output logic          flush,
  output logic [CW-1:0] rx_trig,
  output logic [CW-1:0] tx_trig_eff
);

  trig_code_e rx_code;
  trig_code_e tx_shadow;
  trig_code_e tx_active;
  logic       unused_ctl_bits;

  assign unused_ctl_bits = ^ctl_data[3:1];
  assign flush = ctl_we && !ctl_data[CTL_EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en   <= 1'b0;
      rx_code   <= TRIG_8;
      tx_shadow <= TRIG_8;
    end else if (ctl_we) begin
      fifo_en   <= ctl_data[CTL_EN_BIT];
      rx_code   <= trig_code_e'(ctl_data[CTL_RX_LSB +: 2]);
      tx_shadow <= trig_code_e'(ctl_data[CTL_TX_LSB +: 2]);
    end
  end

  // Legacy mode pins the transmit threshold to the reset value
  assign tx_active   = enh_mode ? tx_shadow : TRIG_8;
  assign rx_trig     = CW'(trig_chars(rx_code));
  assign tx_trig_eff = CW'(trig_chars(tx_active));

  a_r6_legacy_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> tx_trig_eff == CW'(LVL_A));

  a_r2_flush_disables: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !fifo_en);

endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int LIMIT = 40,
  parameter int TW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load_ok,
  input  logic read,
  input  logic tick,
  input  logic below_trig,
  input  logic has_data,
  output logic timeout
);

  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic          armed;
  logic [TW-1:0] timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else if (!enable)
      armed <= 1'b0;
    else if (load_ok)
      armed <= 1'b1;
    else if (read)
      armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      timer <= '0;
    else if (!enable || load_ok || read)
      timer <= '0;
    else if (armed && below_trig && tick && timer != LIM)
      timer <= timer + TW'(1);
  end

  assign timeout = armed && has_data && below_trig && (timer == LIM);

  a_r8_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    timer <= LIM);

  a_r9_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !timeout);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (read && !load_ok) |=> !timeout);

endmodule

// File: rtl/uart_fifo_irq_gen.sv
module uart_fifo_irq_gen
  import uart_fifo_irq_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int BITS_PER_CHAR = 10,
  parameter int TIMEOUT_CHARS = 4,
  parameter int CW            = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          enh_mode,
  input  logic          rx_load,
  input  logic          rhr_read,
  input  logic          tx_write,
  input  logic          tx_take,
  input  logic          baud_tick,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_level_irq,
  output logic          rx_timeout_irq,
  output logic          tx_level_irq
);

  localparam int TICK_LIMIT = BITS_PER_CHAR * TIMEOUT_CHARS;

  logic          fifo_en;
  logic          flush;
  logic [CW-1:0] rx_trig;
  logic [CW-1:0] tx_trig_eff;
  logic [CW-1:0] tx_room_lim;
  logic          rx_push_ok;
  logic          tx_push_ok;
  logic          rx_below;
  logic          tmo_raw;

  trig_ctl #(.CW(CW)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (fcr_we),
    .ctl_data   (fcr_wdata),
    .enh_mode   (enh_mode),
    .fifo_en    (fifo_en),
    .flush      (flush),
    .rx_trig    (rx_trig),
    .tx_trig_eff(tx_trig_eff)
  );

  fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_rx_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .enable (fifo_en),
    .push   (rx_load),
    .pop    (rhr_read),
    .push_ok(rx_push_ok),
    .cnt    (rx_count)
  );

  fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_tx_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .enable (fifo_en),
    .push   (tx_write),
    .pop    (tx_take),
    .push_ok(tx_push_ok),
    .cnt    (tx_count)
  );

  assign rx_below = rx_count < rx_trig;

  rx_timeout #(.LIMIT(TICK_LIMIT)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (fifo_en),
    .load_ok   (rx_push_ok),
    .read      (rhr_read),
    .tick      (baud_tick),
    .below_trig(rx_below),
    .has_data  (rx_count != '0),
    .timeout   (tmo_raw)
  );

  assign tx_room_lim    = CW'(DEPTH) - tx_trig_eff;
  assign rx_level_irq   = fifo_en && !rx_below;
  assign tx_level_irq   = fifo_en && (tx_count <= tx_room_lim);
  assign rx_timeout_irq = fifo_en && tmo_raw;

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!rx_level_irq && !tx_level_irq && !rx_timeout_irq &&
                  rx_count == '0 && tx_count == '0));

  a_r10_timeout_excl_level: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_timeout_irq && rx_level_irq));

  a_r8_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout_irq |-> rx_count != '0);

  a_r4_level_min: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level_irq |-> rx_count >= CW'(LVL_A));

  a_r7_tx_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_ok |-> tx_count != CW'(DEPTH));

endmodule

// File: tb/test_uart_fifo_irq_gen.sv
module test_uart_fifo_irq_gen;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_we = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic       enh_mode = 1'b0;
  logic       rx_load = 1'b0;
  logic       rhr_read = 1'b0;
  logic       tx_write = 1'b0;
  logic       tx_take = 1'b0;
  logic       baud_tick = 1'b0;
  logic [6:0] rx_count;
  logic [6:0] tx_count;
  logic       rx_level_irq;
  logic       rx_timeout_irq;
  logic       tx_level_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_irq_gen i_uart_fifo_irq_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .fcr_we        (fcr_we),
    .fcr_wdata     (fcr_wdata),
    .enh_mode      (enh_mode),
    .rx_load       (rx_load),
    .rhr_read      (rhr_read),
    .tx_write      (tx_write),
    .tx_take       (tx_take),
    .baud_tick     (baud_tick),
    .rx_count      (rx_count),
    .tx_count      (tx_count),
    .rx_level_irq  (rx_level_irq),
    .rx_timeout_irq(rx_timeout_irq),
    .tx_level_irq  (tx_level_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [1:0] rxc, input logic [1:0] txc, input logic en);
    fcr_wdata = {rxc, txc, 3'b000, en};
    fcr_we = 1'b1;
    @(negedge clk);
    fcr_we = 1'b0;
  endtask

  task automatic restart(input logic [1:0] rxc, input logic [1:0] txc);
    ctl(rxc, txc, 1'b0);
    ctl(rxc, txc, 1'b1);
  endtask

  task automatic rx_push(input int n);
    for (int i = 0; i < n; i++) begin
      rx_load = 1'b1;
      @(negedge clk);
    end
    rx_load = 1'b0;
  endtask

  task automatic rx_pop(input int n);
    for (int i = 0; i < n; i++) begin
      rhr_read = 1'b1;
      @(negedge clk);
    end
    rhr_read = 1'b0;
  endtask

  task automatic tx_push(input int n);
    for (int i = 0; i < n; i++) begin
      tx_write = 1'b1;
      @(negedge clk);
    end
    tx_write = 1'b0;
  endtask

  task automatic tx_pop(input int n);
    for (int i = 0; i < n; i++) begin
      tx_take = 1'b1;
      @(negedge clk);
    end
    tx_take = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_level_irq", rx_level_irq, 0);
    check("R1 rx_timeout_irq", rx_timeout_irq, 0);
    check("R1 tx_level_irq", tx_level_irq, 0);
  endtask

  task automatic t_disabled();
    rx_push(3);
    tx_push(2);
    ticks(45);
    check("R2 rx_count disabled", rx_count, 0);
    check("R2 tx_count disabled", tx_count, 0);
    check("R2 tx_level_irq disabled", tx_level_irq, 0);
    check("R2 rx_timeout_irq disabled", rx_timeout_irq, 0);
    ctl(2'b00, 2'b00, 1'b1);
    check("R2 tx_level_irq enabled empty", tx_level_irq, 1);
    rx_push(9);
    tx_push(4);
    ctl(2'b00, 2'b00, 1'b0);
    check("R2 flush rx", rx_count, 0);
    check("R2 flush tx", tx_count, 0);
    check("R2 rx_level_irq flushed", rx_level_irq, 0);
  endtask

  task automatic t_rx_levels();
    int lv[4] = '{8, 16, 56, 60};
    for (int c = 0; c < 4; c++) begin
      restart(2'(c), 2'b00);
      rx_push(lv[c] - 1);
      check($sformatf("R3 R4 below code %0d", c), rx_level_irq, 0);
      rx_push(1);
      check($sformatf("R3 R4 at code %0d", c), rx_level_irq, 1);
      rx_push(1);
      check($sformatf("R4 above code %0d", c), rx_level_irq, 1);
      rx_pop(2);
      check($sformatf("R4 dropped code %0d", c), rx_level_irq, 0);
    end
  endtask

  task automatic t_tx_levels();
    enh_mode = 1'b1;
    restart(2'b00, 2'b10);
    tx_push(8);
    check("R5 R3 tx code 10 at 8", tx_level_irq, 1);
    tx_push(1);
    check("R5 R3 tx code 10 at 9", tx_level_irq, 0);
    restart(2'b00, 2'b01);
    tx_push(48);
    check("R5 tx code 01 at 48", tx_level_irq, 1);
    tx_push(1);
    check("R5 tx code 01 at 49", tx_level_irq, 0);
    enh_mode = 1'b0;
  endtask

  task automatic t_tx_shadow();
    enh_mode = 1'b0;
    restart(2'b00, 2'b11);
    tx_push(56);
    check("R6 legacy at 56", tx_level_irq, 1);
    tx_push(1);
    check("R6 legacy at 57", tx_level_irq, 0);
    enh_mode = 1'b1;
    @(negedge clk);
    check("R6 enhanced at 57", tx_level_irq, 0);
    tx_pop(52);
    check("R6 enhanced at 5", tx_level_irq, 0);
    tx_pop(1);
    check("R6 enhanced at 4", tx_level_irq, 1);
    enh_mode = 1'b0;
    @(negedge clk);
    tx_push(1);
    check("R6 legacy at 5", tx_level_irq, 1);
    enh_mode = 1'b1;
    @(negedge clk);
    check("R6 shadow kept at 5", tx_level_irq, 0);
    enh_mode = 1'b0;
  endtask

  task automatic t_saturate();
    restart(2'b11, 2'b00);
    rx_push(70);
    check("R7 rx full", rx_count, 64);
    tx_push(70);
    check("R7 tx full", tx_count, 64);
    rx_pop(70);
    check("R7 rx empty", rx_count, 0);
    tx_pop(70);
    check("R7 tx empty", tx_count, 0);
    rx_push(5);
    rx_load = 1'b1;
    rhr_read = 1'b1;
    repeat (3) @(negedge clk);
    rx_load = 1'b0;
    rhr_read = 1'b0;
    check("R7 push and pop together", rx_count, 5);
  endtask

  task automatic t_timeout();
    restart(2'b00, 2'b00);
    rx_push(1);
    ticks(39);
    check("R8 before 40 ticks", rx_timeout_irq, 0);
    ticks(1);
    check("R8 at 40 ticks", rx_timeout_irq, 1);
    rx_pop(1);
    check("R9 read clears", rx_timeout_irq, 0);
    rx_push(1);
    ticks(30);
    rx_push(1);
    ticks(30);
    check("R9 restart on load", rx_timeout_irq, 0);
    ticks(10);
    check("R9 fires after restart", rx_timeout_irq, 1);
    rx_push(6);
    check("R10 level reached", rx_level_irq, 1);
    ticks(45);
    check("R10 no timeout at threshold", rx_timeout_irq, 0);
    rx_pop(1);
    ticks(45);
    check("R9 no timeout after read", rx_timeout_irq, 0);
    check("R9 data still held", rx_count, 7);
  endtask

  initial begin
    for (int c = 0; c < WD_CYCLES; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_rx_levels();
    t_tx_levels();
    t_tx_shadow();
    t_saturate();
    t_timeout();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule